// File: doc/BRIEF.md
# Speculative Two-Stage Booth Multiplier

This block multiplies two 16-bit two's-complement operands using radix-4 Booth recoding. It is pipelined in two stages and returns the answer in two steps. One cycle after an operation is issued it presents a speculative upper half of the product, together with a flag. The flag says whether that early value is already exact. One cycle later it presents the exact 32-bit product. A consumer that sees the flag set may forward the early upper half at once. Otherwise it waits one more cycle for the exact result.

Stage 1 builds the Booth partial products and splits every row at the half-product boundary. It sums the upper parts and the lower parts side by side, so neither sum waits for the other. The upper sum is not given the true carry out of the lower sum. It is given a fixed estimated carry (`CARRY_EST`). Stage 1 also takes the difference between the true carry and the estimate. Its sign is kept as the sign bit, and its low `SPLIT` bits are added into the bottom of the speculative upper half. The carry out of that primary compensation adder is kept as the carry bit. The speculation is exact when the sign bit and the carry bit are equal. Stage 2 always adds the sign extension and the carry into the remaining upper bits. It has no result-select multiplexer. One operation can be issued every clock.

Each stage's occupancy is an enumerated slot state with two values, `SLOT_EMPTY` and `SLOT_FULL`. On an edge where the stage's input strobe is high, `SLOT_EMPTY` moves to `SLOT_FULL` and `SLOT_FULL` stays `SLOT_FULL`. On an edge where the strobe is low, `SLOT_FULL` moves to `SLOT_EMPTY` and `SLOT_EMPTY` stays `SLOT_EMPTY`. The input strobe of stage 1 is `in_valid`. The input strobe of stage 2 is the stage-1 slot being full. Reset forces both slots to `SLOT_EMPTY`.

Top module: `spec_booth_mul`

## Requirements
- R1: While `rst_n` is low, `spec_valid`, `spec_ok` and `exact_done` are 0, and `spec_hi` and `exact_prod` are all zeros.
- R2: An operation issued with `in_valid` high at a rising edge raises `spec_valid` after that edge and `exact_done` after the next edge. Each strobe lasts one cycle for each issued operation. Back-to-back issues are accepted every cycle, and cycles with `in_valid` low produce no strobe.
- R3: When `exact_done` is high, `exact_prod` equals the full 32-bit signed product of the operands of the matching issue. This includes the corner operands -32768 and 0.
- R4: When `spec_valid` and `spec_ok` are both high, `spec_hi` equals bits 31:16 of the exact product of the same operation.
- R5: When `spec_valid` is high and `spec_ok` is low, `spec_hi` differs from bits 31:16 of the exact product of the same operation.
- R6: When either operand is zero, the speculation is exact: `spec_ok` is 1 and `spec_hi` is all zeros.
- R7: The speculative upper half is produced with the constant carry estimate `CARRY_EST` (default 4). It is repaired only in stage 2, by adding the stored sign extension and carry into bits above `SPLIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the operands |
| op_a | input | 16 | Multiplicand, two's complement |
| op_b | input | 16 | Multiplier (Booth recoded), two's complement |
| spec_valid | output | 1 | Speculative result present, one cycle after issue |
| spec_hi | output | 16 | Speculative upper half of the product |
| spec_ok | output | 1 | Speculative upper half is exact |
| exact_done | output | 1 | Exact result present, two cycles after issue |
| exact_prod | output | 32 | Exact signed product |

## Verification
A wrong carry estimate, a wrong sign bit or a wrong carry bit shows up one cycle after issue. It appears as `spec_ok` set while `spec_hi` disagrees with the true upper half, or cleared while the two agree. A fault in a partial product or in the correction stage shows up two cycles after issue, as a wrong `exact_prod` on the matching `exact_done` strobe. Operands with many nonzero Booth digits exercise carries of every size into the upper half, and operands of zero pin the zero-carry case.

// File: rtl/spec_booth_pkg.sv
package spec_booth_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_t;

    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_sel_t;

    // Radix-4 recoding of one overlapping bit triplet {b[2i+1], b[2i], b[2i-1]}
    function automatic booth_sel_t booth_decode(input logic [2:0] trip);
        booth_sel_t s;
        s.one = trip[0] ^ trip[1];
        s.two = (trip == 3'b011) || (trip == 3'b100);
        s.neg = trip[2] && !(trip[1] && trip[0]);
        return s;
    endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
    import spec_booth_pkg::*;
#(
    parameter int N   = 16,
    parameter int NPP = N / 2
) (
    input  logic [N-1:0]              mcand,
    input  logic [N-1:0]              mplier,
    output logic [NPP-1:0][2*N-1:0]   pp
);
    localparam int PW = 2 * N;

    // Multiplier with an implicit zero below its LSB
    logic [N:0]    mx;
    logic [PW-1:0] a_ext;

    assign mx    = {mplier, 1'b0};
    assign a_ext = {{N{mcand[N-1]}}, mcand};

    for (genvar g = 0; g < NPP; g++) begin : g_row
        booth_sel_t    sel;
        logic [PW-1:0] mag;
        logic [PW-1:0] sgn;

        assign sel = booth_decode(mx[2*g+2 : 2*g]);

        always_comb begin
            if (sel.one)      mag = a_ext;
            else if (sel.two) mag = a_ext << 1;
            else              mag = '0;
            sgn = sel.neg ? (~mag + PW'(1)) : mag;
        end

        assign pp[g] = sgn << (2 * g);
    end

endmodule

// File: rtl/booth_part_sum.sv
module booth_part_sum #(
    parameter int N   = 16,
    parameter int NPP = N / 2,
    parameter int LW  = N + $clog2(NPP)
) (
    input  logic [NPP-1:0][2*N-1:0] pp,
    output logic [N-1:0]            hi_sum,
    output logic [LW-1:0]           lo_sum
);
    // Upper and lower parts of every row summed independently
    always_comb begin
        hi_sum = '0;
        lo_sum = '0;
        for (int i = 0; i < NPP; i++) begin
            hi_sum = hi_sum + pp[i][2*N-1:N];
            lo_sum = lo_sum + LW'(pp[i][N-1:0]);
        end
    end

endmodule

// File: rtl/booth_fix_stage.sv
module booth_fix_stage
    import spec_booth_pkg::*;
#(
    parameter int N     = 16,
    parameter int SPLIT = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s1_full,
    input  logic [N-1:0]   s1_hi,
    input  logic [N-1:0]   s1_lo,
    input  logic           s1_sign,
    input  logic           s1_carry,
    output logic           done,
    output logic [2*N-1:0] prod
);
    localparam int UW = N - SPLIT;

    slot_t          st_q, st_d;
    logic [UW-1:0]  upper_fix;
    logic [2*N-1:0] prod_d;

    // Correction always applied: sign extension plus stored carry
    assign upper_fix = s1_hi[N-1:SPLIT] + {UW{s1_sign}} + UW'(s1_carry);
    assign prod_d    = {upper_fix, s1_hi[SPLIT-1:0], s1_lo};

    always_comb begin
        unique case (st_q)
            SLOT_EMPTY: st_d = s1_full ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL:  st_d = s1_full ? SLOT_FULL : SLOT_EMPTY;
            default:    st_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SLOT_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prod <= '0;
        else if (s1_full) prod <= prod_d;
    end

    assign done = (st_q == SLOT_FULL);

endmodule

// File: rtl/spec_booth_mul.sv
module spec_booth_mul
    import spec_booth_pkg::*;
#(
    parameter int N         = 16,
    parameter int SPLIT     = 8,
    parameter int CARRY_EST = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic           spec_valid,
    output logic [N-1:0]   spec_hi,
    output logic           spec_ok,
    output logic           exact_done,
    output logic [2*N-1:0] exact_prod
);
    localparam int NPP = N / 2;
    localparam int CB  = $clog2(NPP);
    localparam int LW  = N + CB;
    localparam int DW  = CB + 1;

    logic [NPP-1:0][2*N-1:0] pp;
    logic [N-1:0]            hi_sum;
    logic [LW-1:0]           lo_sum;

    booth_pp_gen #(.N(N), .NPP(NPP)) u_pp (
        .mcand (op_a),
        .mplier(op_b),
        .pp    (pp)
    );

    booth_part_sum #(.N(N), .NPP(NPP), .LW(LW)) u_sum (
        .pp    (pp),
        .hi_sum(hi_sum),
        .lo_sum(lo_sum)
    );

    // Stage 1: speculation and primary compensation
    logic [CB-1:0]    c_true;
    logic [DW-1:0]    c_diff;
    logic             d_sign;
    logic [SPLIT-1:0] d_ext;
    logic [N-1:0]     spec_full;
    logic [SPLIT-1:0] low_fix;
    logic             c_fix;

    assign c_true    = lo_sum[LW-1:N];
    assign c_diff    = {1'b0, c_true} - DW'(CARRY_EST);
    assign d_sign    = c_diff[DW-1];
    assign d_ext     = {{(SPLIT-DW){d_sign}}, c_diff};
    assign spec_full = hi_sum + N'(CARRY_EST);
    assign {c_fix, low_fix} = {1'b0, spec_full[SPLIT-1:0]} + {1'b0, d_ext};

    slot_t        s1_q, s1_d;
    logic [N-1:0] r_hi, r_lo;
    logic         r_sign, r_carry;

    always_comb begin
        unique case (s1_q)
            SLOT_EMPTY: s1_d = in_valid ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL:  s1_d = in_valid ? SLOT_FULL : SLOT_EMPTY;
            default:    s1_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= SLOT_EMPTY;
        else        s1_q <= s1_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_hi    <= '0;
            r_lo    <= '0;
            r_sign  <= 1'b0;
            r_carry <= 1'b0;
        end else if (in_valid) begin
            r_hi    <= {spec_full[N-1:SPLIT], low_fix};
            r_lo    <= lo_sum[N-1:0];
            r_sign  <= d_sign;
            r_carry <= c_fix;
        end
    end

    always_comb begin
        spec_valid = (s1_q == SLOT_FULL);
        spec_hi    = r_hi;
        spec_ok    = spec_valid && (r_sign == r_carry);
    end

    // Stage 2: unconditional correction of the upper bits
    booth_fix_stage #(.N(N), .SPLIT(SPLIT)) u_fix (
        .clk     (clk),
        .rst_n   (rst_n),
        .s1_full (spec_valid),
        .s1_hi   (r_hi),
        .s1_lo   (r_lo),
        .s1_sign (r_sign),
        .s1_carry(r_carry),
        .done    (exact_done),
        .prod    (exact_prod)
    );

endmodule

// File: rtl/spec_booth_mul_chk.sv
module spec_booth_mul_chk #(
    parameter int N = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic           spec_valid,
    input logic [N-1:0]   spec_hi,
    input logic           spec_ok,
    input logic           exact_done,
    input logic [2*N-1:0] exact_prod
);
    logic signed [2*N-1:0] prod_in;
    assign prod_in = $signed(op_a) * $signed(op_b);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!spec_valid && !exact_done && !spec_ok); // R1
        end
    end

    AST_SPEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> spec_valid); // R2
    AST_NO_SPEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !spec_valid); // R2
    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        spec_valid |=> exact_done); // R2
    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_valid |=> !exact_done); // R2
    AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 (exact_prod == $past(prod_in, 2))); // R3
    AST_SPEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_valid && spec_ok) |=> (exact_prod[2*N-1:N] == $past(spec_hi))); // R4
    AST_SPEC_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_valid && !spec_ok) |=> (exact_prod[2*N-1:N] != $past(spec_hi))); // R5
    AST_ZERO_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_a == '0 || op_b == '0)) |=> (spec_ok && spec_hi == '0)); // R6

endmodule

bind spec_booth_mul spec_booth_mul_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .spec_valid(spec_valid),
    .spec_hi   (spec_hi),
    .spec_ok   (spec_ok),
    .exact_done(exact_done),
    .exact_prod(exact_prod)
);

// File: tb/spec_booth_mul_bench.sv
module spec_booth_mul_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        spec_valid, spec_ok, exact_done;
    logic [15:0] spec_hi;
    logic [31:0] exact_prod;

    int total = 0;
    int bad   = 0;
    int n_hit = 0;
    int n_miss = 0;

    always #10 clk = ~clk;

    spec_booth_mul u_spec_booth_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .spec_valid(spec_valid),
        .spec_hi   (spec_hi),
        .spec_ok   (spec_ok),
        .exact_done(exact_done),
        .exact_prod(exact_prod)
    );

    // Bench-side pipeline of issued operations
    bit          p1_v = 0, p2_v = 0;
    logic [15:0] p1_a, p1_b, p2_a, p2_b;

    function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] r;
        r = $signed(a) * $signed(b);
        return r;
    endfunction

    task automatic check(input bit cond, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [15:0] a, input logic [15:0] b);
        logic [31:0] e1, e2;
        @(negedge clk);
        check(spec_valid == p1_v, "R2 spec_valid", 32'(spec_valid), 32'(p1_v));
        check(exact_done == p2_v, "R2 exact_done", 32'(exact_done), 32'(p2_v));
        if (p1_v) begin
            e1 = ref_mul(p1_a, p1_b);
            if (spec_ok) begin
                n_hit++;
                check(spec_hi == e1[31:16], "R4 spec_hi when ok", 32'(spec_hi), 32'(e1[31:16]));
            end else begin
                n_miss++;
                check(spec_hi != e1[31:16], "R5 spec_hi when not ok", 32'(spec_hi), 32'(e1[31:16]));
            end
            if (p1_a == '0 || p1_b == '0)
                check(spec_ok && spec_hi == '0, "R6 zero operand", {spec_hi, 15'd0, spec_ok},
                      32'd1);
        end
        if (p2_v) begin
            e2 = ref_mul(p2_a, p2_b);
            check(exact_prod == e2, "R3 exact product", exact_prod, e2);
        end
        p2_v = p1_v; p2_a = p1_a; p2_b = p1_b;
        p1_v = v;    p1_a = a;    p1_b = b;
        in_valid = v;
        op_a = a;
        op_b = b;
    endtask

    initial begin
        #3000000;
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] corner [12];
        int k;
        corner = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0002, 16'hFFFE, 16'h0003,
                   16'h7FFF, 16'h8000, 16'h8001, 16'h5555, 16'hAAAA, 16'h00FF};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check(!spec_valid && !spec_ok && !exact_done, "R1 strobes in reset",
              {29'd0, spec_valid, spec_ok, exact_done}, 32'd0);
        check(spec_hi == '0 && exact_prod == '0, "R1 data in reset", exact_prod | 32'(spec_hi),
              32'd0);
        rst_n = 1'b1;
        // R3/R6: corner pairs, with an idle gap every fifth issue (R2)
        k = 0;
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                step(1'b1, corner[i], corner[j]);
                k++;
                if (k % 5 == 0) step(1'b0, 16'h1234, 16'h4321);
            end
        end
        // R4/R5: random operands, back-to-back
        for (int i = 0; i < 4000; i++) begin
            step(1'b1, 16'($urandom), 16'($urandom));
            if (i % 97 == 0) step(1'b0, '0, '0);
        end
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        // R7: a fixed estimate must sometimes hit and sometimes miss
        check(n_hit > 0, "R7 speculation hits", 32'(n_hit), 32'd1);
        check(n_miss > 0, "R7 speculation misses", 32'(n_miss), 32'd1);
        $display("speculation hits=%0d misses=%0d", n_hit, n_miss);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule